// File: doc/BRIEF.md
# Control Endpoint Setup Lockout Controller

This block manages what a device controller's microcontroller may do to its two control endpoints, OUT and IN, once a SETUP packet comes in. A setup arrival from the packet engine blocks the buffer-validate and buffer-clear commands on both control endpoints. Each endpoint is released only by its own acknowledge-setup command. The block flags a SETUP that lands on top of an earlier one that was neither acknowledged nor stalled. That sticky overwrite flag is released by a status read, but only once the packet engine has finished writing the new setup data.

The CPU talks to the block through a byte-wide command strobe plus an endpoint select bit. Validate and clear commands are forwarded as one-cycle pulses when they are accepted. When they are refused, a reject pulse is raised. The block also stores a last-transaction error code for each of sixteen endpoints, and the CPU reads these back by command. A read clears the code's unread marker.

Top module: `ctl_setup_gate`

## Requirements
- R1: A `setup_arrive` pulse locks both control endpoints. From the next cycle on, `val_en` and `clr_en` read 2'b00. Bit 0 is OUT and bit 1 is IN.
- R2: Command 0xF4 (acknowledge) unlocks only the endpoint named by `cmd_ep`, where 0 is OUT and 1 is IN. The other endpoint stays locked. If a `setup_arrive` comes in the same cycle, the lock wins.
- R3: A validate command (0xFA) or clear command (0xF2) aimed at a locked endpoint is ignored. It gives no `val_go`/`clr_go` pulse, the buffer-select bit does not change, and `cmd_reject` pulses high in the next cycle.
- R4: An accepted validate gives a one-cycle pulse on `val_go[cmd_ep]` and toggles that endpoint's buffer-select bit. An accepted clear gives a one-cycle pulse on `clr_go[cmd_ep]`, and on the OUT endpoint it also clears the setup-present flag.
- R5: A `setup_arrive` sets the overwrite flag when either endpoint is still locked and no stall has been requested since the previous arrival.
- R6: A `stall_req` pulse on either bit marks the current setup as handled. The next `setup_arrive` then does not set the overwrite flag.
- R7: Status command 0xD0 returns one byte on `rd_data` with `rd_valid` high: bit 3 overwrite, bit 2 setup-present, bit 1 buffer-select of `cmd_ep` (0 primary, 1 secondary), all other bits 0. The read clears the overwrite flag only if a `setup_done` has arrived since the last `setup_arrive`. The byte returned still shows the flag as it was before the read.
- R8: A `txn_valid` pulse stores the byte {unread=1, toggle, 1'b0, err[3:0], ok} for endpoint `txn_ep`, replacing that endpoint's previous code.
- R9: Command 0xA0+n returns endpoint n's stored code, where n=0 is control OUT, n=1 is control IN and n=2..15 are endpoints 1 to 14. The read then clears that code's unread bit (bit 7). A store to the same endpoint in the same cycle takes precedence.
- R10: After reset both endpoints are unlocked, every error code and flag is 0, and `rd_valid`, `cmd_reject` and all go pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe from the CPU |
| cmd_code | input | 8 | Command byte |
| cmd_ep | input | 1 | Target control endpoint (0 OUT, 1 IN) |
| setup_arrive | input | 1 | A SETUP packet has arrived |
| setup_done | input | 1 | Writing of the setup data has finished |
| stall_req | input | 2 | Stall request per control endpoint |
| txn_valid | input | 1 | Transaction result strobe |
| txn_ep | input | 4 | Endpoint index of the transaction result |
| txn_toggle | input | 1 | Data toggle of the transaction |
| txn_err | input | 4 | Error field of the transaction |
| txn_ok | input | 1 | Transaction completed successfully |
| val_en | output | 2 | Validate command enabled, per endpoint |
| clr_en | output | 2 | Clear command enabled, per endpoint |
| val_go | output | 2 | Accepted validate pulse, per endpoint |
| clr_go | output | 2 | Accepted clear pulse, per endpoint |
| cmd_reject | output | 1 | Validate or clear refused |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Status or error-code byte |

## Verification
Every result here comes from a single register. A command, setup pulse, stall or transaction captured at one rising edge therefore shows up on the outputs for the whole following cycle, and one cycle later it has dropped again. The bench drives each stimulus at a falling edge and samples at the next falling edge, which is exactly one register stage later. Go and reject pulses are also checked for absence at that same point. Sticky effects, such as locks, the overwrite flag and unread bits, are confirmed later through status and error-code reads.

// File: rtl/ctl_setup_gate.sv
module ctl_setup_gate #(
  parameter logic [7:0] CMD_ACK  = 8'hF4,
  parameter logic [7:0] CMD_VAL  = 8'hFA,
  parameter logic [7:0] CMD_CLR  = 8'hF2,
  parameter logic [7:0] CMD_STAT = 8'hD0,
  parameter logic [3:0] CMD_ERR  = 4'hA,
  parameter int         NUM_EP   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       cmd_ep,
  input  logic       setup_arrive,
  input  logic       setup_done,
  input  logic [1:0] stall_req,
  input  logic       txn_valid,
  input  logic [3:0] txn_ep,
  input  logic       txn_toggle,
  input  logic [3:0] txn_err,
  input  logic       txn_ok,
  output logic [1:0] val_en,
  output logic [1:0] clr_en,
  output logic [1:0] val_go,
  output logic [1:0] clr_go,
  output logic       cmd_reject,
  output logic       rd_valid,
  output logic [7:0] rd_data
);

  logic [1:0] lock, bsel;
  logic       setup_q, wr_done, stalled, ovw;
  logic [7:0] err_mem [NUM_EP];

  wire is_ack  = cmd_valid && cmd_code == CMD_ACK;
  wire is_val  = cmd_valid && cmd_code == CMD_VAL;
  wire is_clr  = cmd_valid && cmd_code == CMD_CLR;
  wire is_stat = cmd_valid && cmd_code == CMD_STAT;
  wire is_err  = cmd_valid && cmd_code[7:4] == CMD_ERR;
  wire ep_lock = lock[cmd_ep];
  wire ovw_set = setup_arrive && (|lock) && !stalled;

  assign val_en = ~lock;
  assign clr_en = ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 2'b00;
      bsel    <= 2'b00;
      setup_q <= 1'b0;
      wr_done <= 1'b1;
      stalled <= 1'b0;
      ovw     <= 1'b0;
    end else begin
      if (setup_arrive)  lock <= 2'b11;
      else if (is_ack)   lock[cmd_ep] <= 1'b0;

      if (setup_arrive)    stalled <= 1'b0;
      else if (|stall_req) stalled <= 1'b1;

      if (setup_arrive)    wr_done <= 1'b0;
      else if (setup_done) wr_done <= 1'b1;

      if (setup_arrive) setup_q <= 1'b1;
      else if (is_clr && !ep_lock && !cmd_ep) setup_q <= 1'b0;

      if (ovw_set)                  ovw <= 1'b1;
      else if (is_stat && wr_done)  ovw <= 1'b0;

      if (is_val && !ep_lock) bsel[cmd_ep] <= ~bsel[cmd_ep];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_go     <= 2'b00;
      clr_go     <= 2'b00;
      cmd_reject <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
    end else begin
      val_go     <= (is_val && !ep_lock) ? (2'b01 << cmd_ep) : 2'b00;
      clr_go     <= (is_clr && !ep_lock) ? (2'b01 << cmd_ep) : 2'b00;
      cmd_reject <= (is_val || is_clr) && ep_lock;
      rd_valid   <= is_stat || is_err;
      if (is_stat)     rd_data <= {4'b0000, ovw, setup_q, bsel[cmd_ep], 1'b0};
      else if (is_err) rd_data <= err_mem[cmd_code[3:0]];
      else             rd_data <= 8'h00;
    end
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        err_mem[i] <= 8'h00;
      else if (txn_valid && txn_ep == 4'(i))
        err_mem[i] <= {1'b1, txn_toggle, 1'b0, txn_err, txn_ok};
      else if (is_err && cmd_code[3:0] == 4'(i))
        err_mem[i][7] <= 1'b0;
    end
  end

  AST_SETUP_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    setup_arrive |=> (val_en == 2'b00 && clr_en == 2'b00)); // R1
  AST_ACK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ack && !cmd_ep && !setup_arrive) |=> val_en[0]); // R2
  AST_ACK_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ack && cmd_ep && !setup_arrive) |=> val_en[1]); // R2
  AST_LOCKED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_val || is_clr) && ep_lock) |=> (cmd_reject && val_go == 2'b00 && clr_go == 2'b00)); // R3
  AST_GO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({val_go, clr_go})); // R4
  AST_OVW_FROM_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovw) |-> $past(setup_arrive)); // R5
  AST_STALL_NO_OVW: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_arrive && stalled) |=> !$rose(ovw)); // R6
  AST_OVW_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stat && !wr_done && ovw) |=> ovw); // R7
  AST_ERR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_err && !(txn_valid && txn_ep == cmd_code[3:0])) |=> !err_mem[$past(cmd_code[3:0])][7]); // R9

endmodule

// File: tb/ctl_setup_gate_tb.sv
`timescale 1ns/1ps
module ctl_setup_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic       cmd_ep = 1'b0;
  logic       setup_arrive = 1'b0, setup_done = 1'b0;
  logic [1:0] stall_req = 2'b00;
  logic       txn_valid = 1'b0, txn_toggle = 1'b0, txn_ok = 1'b0;
  logic [3:0] txn_ep = 4'h0, txn_err = 4'h0;
  logic [1:0] val_en, clr_en, val_go, clr_go;
  logic       cmd_reject, rd_valid;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctl_setup_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_ep(cmd_ep),
    .setup_arrive(setup_arrive), .setup_done(setup_done), .stall_req(stall_req),
    .txn_valid(txn_valid), .txn_ep(txn_ep), .txn_toggle(txn_toggle), .txn_err(txn_err),
    .txn_ok(txn_ok), .val_en(val_en), .clr_en(clr_en), .val_go(val_go), .clr_go(clr_go),
    .cmd_reject(cmd_reject), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // {cv, code, ep, setup_arrive, setup_done, stall[1:0], exp_en[1:0], exp_rdv, exp_rd[7:0], exp_rej, exp_go{val,clr}}
  localparam int NV = 23;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1, 8'h00, 1'b0, 4'b0000},
    {1'b1, 8'hFA, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0, 8'h00, 1'b0, 4'b0100},
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1, 8'h02, 1'b0, 4'b0000},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b1, 8'hFA, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 4'b0000},
    {1'b1, 8'hF2, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 4'b0000},
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 8'h06, 1'b0, 4'b0000},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 8'h0E, 1'b0, 4'b0000},
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 8'h0E, 1'b0, 4'b0000},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 8'h0E, 1'b0, 4'b0000},
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 8'h06, 1'b0, 4'b0000},
    {1'b1, 8'hF4, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b1, 8'hFA, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01, 1'b0, 8'h00, 1'b1, 4'b0000},
    {1'b1, 8'hFA, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 1'b0, 8'h00, 1'b0, 4'b0100},
    {1'b1, 8'hF4, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b1, 8'hF2, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0, 8'h00, 1'b0, 4'b0001},
    {1'b1, 8'hD0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1, 8'h00, 1'b0, 4'b0000},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 8'h00, 1'b0, 4'b0000},
    {1'b1, 8'hD0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b1, 8'h04, 1'b0, 4'b0000}
  };
  string tags [NV] = '{"R10", "R4", "R4", "R1", "R3", "R3", "R7", "R5", "R7", "R7", "R7",
                       "R7", "R7", "R2", "R2", "R4", "R2", "R4", "R4", "R1", "R6", "R6", "R6"};

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cmd_valid = 0; cmd_code = 8'h00; cmd_ep = 0; setup_arrive = 0; setup_done = 0;
    stall_req = 2'b00; txn_valid = 0;
  endtask

  task automatic err_read(input logic [3:0] ep, input logic [7:0] exp, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_code = {4'hA, ep};
    @(negedge clk);
    chk(req, "error read valid", 32'(rd_valid), 32'd1);
    chk(req, "error read data", 32'(rd_data), 32'(exp));
    idle();
  endtask

  task automatic store(input logic [3:0] ep, input logic tog, input logic [3:0] e, input logic ok);
    @(negedge clk);
    txn_valid = 1; txn_ep = ep; txn_toggle = tog; txn_err = e; txn_ok = ok;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "val_en", 32'(val_en), 32'h3);
    chk("R10", "clr_en", 32'(clr_en), 32'h3);
    chk("R10", "rd_valid", 32'(rd_valid), 32'h0);
    chk("R10", "go/reject", 32'({val_go, clr_go, cmd_reject}), 32'h0);
    err_read(4'h7, 8'h00, "R10");

    for (int k = 0; k < NV; k++) begin
      logic [29:0] v;
      v = VEC[k];
      @(negedge clk);
      cmd_valid = v[29]; cmd_code = v[28:21]; cmd_ep = v[20];
      setup_arrive = v[19]; setup_done = v[18]; stall_req = v[17:16];
      @(negedge clk);
      chk(tags[k], $sformatf("vec %0d val_en", k), 32'(val_en), 32'(v[15:14]));
      chk(tags[k], $sformatf("vec %0d clr_en", k), 32'(clr_en), 32'(v[15:14]));
      chk(tags[k], $sformatf("vec %0d rd_valid", k), 32'(rd_valid), 32'(v[13]));
      chk(tags[k], $sformatf("vec %0d rd_data", k), 32'(rd_data), 32'(v[12:5]));
      chk(tags[k], $sformatf("vec %0d reject", k), 32'(cmd_reject), 32'(v[4]));
      chk(tags[k], $sformatf("vec %0d go", k), 32'({val_go, clr_go}), 32'(v[3:0]));
      idle();
    end

    // R8 / R9 error codes
    store(4'h5, 1'b1, 4'hA, 1'b0);
    err_read(4'h5, 8'hD4, "R8");
    err_read(4'h5, 8'h54, "R9");
    err_read(4'h4, 8'h00, "R9");
    store(4'h0, 1'b0, 4'h0, 1'b1);
    err_read(4'h0, 8'h81, "R8");
    store(4'h5, 1'b0, 4'h3, 1'b1);
    err_read(4'h5, 8'h87, "R8");
    // R9 store and read of same endpoint in one cycle: store wins, old value returned
    @(negedge clk);
    cmd_valid = 1; cmd_code = 8'hA5;
    txn_valid = 1; txn_ep = 4'h5; txn_toggle = 1; txn_err = 4'h1; txn_ok = 0;
    @(negedge clk);
    chk("R9", "read during store", 32'(rd_data), 32'h07);
    idle();
    err_read(4'h5, 8'hC2, "R9");

    // R2 ack and setup together: lock wins
    @(negedge clk);
    cmd_valid = 1; cmd_code = 8'hF4; cmd_ep = 0; setup_arrive = 1;
    @(negedge clk);
    chk("R2", "ack with setup", 32'(val_en), 32'h0);
    idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule